// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block keeps the status byte of a byte-addressed serial nonvolatile memory and decides, cycle by cycle, whether a write may go ahead. The command decoder in front of it sends single-cycle strobes: set the write latch, clear the write latch, write the status byte, and write to the array. Alongside the strobes it gives the level of the write-protect pin and the array address that a write would target. The block answers with the status byte, a permit flag for the given address, a permit flag for a status write, a busy flag, and a one-cycle pulse whenever a write request is refused.

Two block-protect bits mark an upper range of the array as read-only. The range is a quarter, a half or the whole array. A write latch must be set before any write is allowed. The latch is cleared again when the write cycle ends. A hardware lock is active when the protect pin is low and a status enable bit is set. It freezes the status byte but still lets unprotected array addresses be written. The protect bits and the enable bit keep their values across a reset. A self-timed write is modelled by a counter of `WR_CYCLES` clock cycles. The array is 16K or 32K bytes, chosen by `ARRAY_BYTES`.

Top module: `wp_ctrl`

## Requirements
- R1: After reset the write latch (status bit 1) is 0, the busy bit (status bit 0) is 0 and `reject_o` is 0. Status bits 6 to 4 always read 0.
- R2: When the block is idle, `wren_i` sets the write latch on the next clock and `wrdi_i` clears it.
- R3: Protect code `bp` (status bits 3:2) selects the read-only range. 00 protects nothing. 01 protects the top quarter, which is 0x6000 and up for 32K. 10 protects the top half, which is 0x4000 and up. 11 protects every address. `arr_wr_ok_o` is 1 exactly when the latch is set, the block is idle and the address is outside the range.
- R4: An array write to a protected address is refused whatever the latch, pin and enable bit hold. `reject_o` pulses high for one cycle, the busy bit is not set and the status byte is unchanged.
- R5: An array write to an unprotected address while the latch is set is accepted, even when the hardware lock is active.
- R6: The hardware lock is active when `wp_n_i` is 0 and the enable bit (status bit 7) is 1. While it is active, `sr_wr_ok_o` is 0 and a status write is refused with a reject pulse, leaving the status byte unchanged.
- R7: Without the hardware lock, a status write is accepted exactly when the latch is set. It loads the enable bit from `wrsr_data_i[7]` and `bp` from `wrsr_data_i[3:2]`. Data bit 0 never changes the busy bit.
- R8: An accepted write holds the busy bit at 1 for exactly `WR_CYCLES` cycles, starting on the clock after the request. When the busy bit falls, the write latch is 0.
- R9: While busy, every strobe is ignored. There is no reject pulse and no change to the status byte, and both permit flags read 0.
- R10: The protect code and the enable bit keep their values through a reset.
- R11: When several strobes arrive in the same cycle, only the highest-ranked one acts: status write first, then array write, then latch set, then latch clear.
- R12: Any write request made while the latch is 0 is refused with a reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears latch, busy and reject only |
| wren_i | input | 1 | Strobe: set the write latch |
| wrdi_i | input | 1 | Strobe: clear the write latch |
| wrsr_i | input | 1 | Strobe: write the status byte |
| wrsr_data_i | input | 8 | Data for a status write |
| wrarr_i | input | 1 | Strobe: array write request at `addr_i` |
| addr_i | input | AW | Candidate array address |
| wp_n_i | input | 1 | Write-protect pin level, low means asserted |
| status_o | output | 8 | Status byte {en, 0, 0, 0, bp1, bp0, latch, busy} |
| arr_wr_ok_o | output | 1 | Array write would be accepted at `addr_i` |
| sr_wr_ok_o | output | 1 | Status write would be accepted |
| busy_o | output | 1 | Self-timed write in progress |
| reject_o | output | 1 | One-cycle pulse after a refused write request |

## Verification
Several rules are checked on every cycle. A refused array write must give a reject pulse and no busy bit, and an accepted one must give busy without a reject. The hardware lock must drive the status permit low. The protect bits must stay stable while busy, the permits must read 0 while busy, and the latch must be clear when busy falls. Other behaviour needs the bench's reference model and its scenarios: the address boundaries of each protect code, the exact length of the busy window, strobe priority, and the protect bits surviving a reset.

// File: rtl/wp_ctrl_pkg.sv
package wp_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRSR,
        OP_WRARR,
        OP_WREN,
        OP_WRDI
    } op_t;

    typedef struct packed {
        logic wel;
        logic reject;
    } ctl_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } nv_t;

endpackage

// File: rtl/wp_ctrl_arbiter.sv
module wp_ctrl_arbiter
    import wp_ctrl_pkg::*;
(
    input  logic wrsr_i,
    input  logic wrarr_i,
    input  logic wren_i,
    input  logic wrdi_i,
    output op_t  op_o
);
    always_comb begin
        if (wrsr_i)       op_o = OP_WRSR;
        else if (wrarr_i) op_o = OP_WRARR;
        else if (wren_i)  op_o = OP_WREN;
        else if (wrdi_i)  op_o = OP_WRDI;
        else              op_o = OP_NONE;
    end
endmodule

// File: rtl/wp_ctrl_range.sv
module wp_ctrl_range #(
    parameter int ARRAY_BYTES = 32768,
    parameter int AW          = $clog2(ARRAY_BYTES)
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    bp_i,
    output logic          prot_o
);
    localparam int          QTR_BASE  = ARRAY_BYTES - ARRAY_BYTES / 4;
    localparam int          HALF_BASE = ARRAY_BYTES / 2;
    localparam logic [AW:0] QTR_LIM   = (AW+1)'(QTR_BASE);
    localparam logic [AW:0] HALF_LIM  = (AW+1)'(HALF_BASE);

    logic [AW:0] addr_ext;
    logic        in_qtr;
    logic        in_half;

    assign addr_ext = {1'b0, addr_i};
    assign in_qtr   = (addr_ext >= QTR_LIM);
    assign in_half  = (addr_ext >= HALF_LIM);

    always_comb begin
        unique case (bp_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = in_qtr;
            2'b10:   prot_o = in_half;
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_ctrl_timer.sv
module wp_ctrl_timer #(
    parameter int WR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic finish_o
);
    localparam int           CW   = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        finish_o = 1'b0;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == CW'(1)) begin
                finish_o  = 1'b1;
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_ctrl_pkg::*;
#(
    parameter int ARRAY_BYTES = 32768,
    parameter int WR_CYCLES   = 8,
    parameter int AW          = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wren_i,
    input  logic          wrdi_i,
    input  logic          wrsr_i,
    input  logic [7:0]    wrsr_data_i,
    input  logic          wrarr_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wp_n_i,
    output logic [7:0]    status_o,
    output logic          arr_wr_ok_o,
    output logic          sr_wr_ok_o,
    output logic          busy_o,
    output logic          reject_o
);
    ctl_t ctl_d, ctl_q;
    nv_t  nv_d, nv_q;
    op_t  op;
    logic prot;
    logic hw_lock;
    logic busy;
    logic finish;
    logic start;
    logic arr_ok;
    logic sr_ok;

    wp_ctrl_arbiter u_arb (
        .wrsr_i (wrsr_i),
        .wrarr_i(wrarr_i),
        .wren_i (wren_i),
        .wrdi_i (wrdi_i),
        .op_o   (op)
    );

    wp_ctrl_range #(.ARRAY_BYTES(ARRAY_BYTES), .AW(AW)) u_range (
        .addr_i(addr_i),
        .bp_i  (nv_q.bp),
        .prot_o(prot)
    );

    wp_ctrl_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .finish_o(finish)
    );

    assign hw_lock = ~wp_n_i & nv_q.wpen;
    assign sr_ok   = ctl_q.wel & ~hw_lock & ~busy;
    assign arr_ok  = ctl_q.wel & ~prot & ~busy;

    always_comb begin
        ctl_d        = ctl_q;
        nv_d         = nv_q;
        ctl_d.reject = 1'b0;
        start        = 1'b0;
        if (!busy) begin
            unique case (op)
                OP_WRSR: begin
                    if (sr_ok) begin
                        start     = 1'b1;
                        nv_d.wpen = wrsr_data_i[7];
                        nv_d.bp   = wrsr_data_i[3:2];
                    end else begin
                        ctl_d.reject = 1'b1;
                    end
                end
                OP_WRARR: begin
                    if (arr_ok) start = 1'b1;
                    else        ctl_d.reject = 1'b1;
                end
                OP_WREN: ctl_d.wel = 1'b1;
                OP_WRDI: ctl_d.wel = 1'b0;
                default: ;
            endcase
        end
        if (finish) ctl_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // nonvolatile bits: deliberately outside the reset
    always_ff @(posedge clk) begin
        nv_q <= nv_d;
    end

    assign status_o    = {nv_q.wpen, 3'b000, nv_q.bp, ctl_q.wel, busy};
    assign arr_wr_ok_o = arr_ok;
    assign sr_wr_ok_o  = sr_ok;
    assign busy_o      = busy;
    assign reject_o    = ctl_q.reject;
endmodule

// File: rtl/wp_ctrl_checker.sv
module wp_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wren_i,
    input logic       wrsr_i,
    input logic       wrarr_i,
    input logic       wp_n_i,
    input logic       st_wpen,
    input logic [1:0] st_bp,
    input logic       st_wel,
    input logic       arr_wr_ok_o,
    input logic       sr_wr_ok_o,
    input logic       busy_o,
    input logic       reject_o
);
    // R4
    arr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrarr_i && !wrsr_i && !busy_o && !arr_wr_ok_o) |=> (reject_o && !busy_o));

    // R5
    arr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrarr_i && !wrsr_i && arr_wr_ok_o) |=> (busy_o && !reject_o));

    // R6
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_i && st_wpen) |-> !sr_wr_ok_o);

    // R8
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !st_wel);

    // R9
    busy_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(st_bp) && $stable(st_wpen)));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!reject_o && !arr_wr_ok_o && !sr_wr_ok_o));

    // R2
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_i && !wrsr_i && !wrarr_i && !busy_o) |=> st_wel);
endmodule

bind wp_ctrl wp_ctrl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wren_i     (wren_i),
    .wrsr_i     (wrsr_i),
    .wrarr_i    (wrarr_i),
    .wp_n_i     (wp_n_i),
    .st_wpen    (status_o[7]),
    .st_bp      (status_o[3:2]),
    .st_wel     (status_o[1]),
    .arr_wr_ok_o(arr_wr_ok_o),
    .sr_wr_ok_o (sr_wr_ok_o),
    .busy_o     (busy_o),
    .reject_o   (reject_o)
);

// File: tb/wp_ctrl_tb.sv
module wp_ctrl_tb;
    localparam int SIZE = 32768;
    localparam int NCYC = 8;
    localparam int AW   = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, wrarr_i = 1'b0;
    logic [7:0]    wrsr_data_i = 8'h00;
    logic [AW-1:0] addr_i = '0;
    logic          wp_n_i = 1'b1;
    logic [7:0]    status_o;
    logic          arr_wr_ok_o, sr_wr_ok_o, busy_o, reject_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    int m_wel = 0, m_rdy = 0, m_cnt = 0, m_rej = 0;
    int m_wpen = 0, m_bp = 0, m_known = 0;

    always #4 clk = ~clk;

    wp_ctrl #(.ARRAY_BYTES(SIZE), .WR_CYCLES(NCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .wrarr_i(wrarr_i),
        .addr_i(addr_i), .wp_n_i(wp_n_i), .status_o(status_o),
        .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o),
        .busy_o(busy_o), .reject_o(reject_o)
    );

    function automatic int is_prot(int bp, int a);
        if (bp == 0) return 0;
        if (bp == 1) return (a >= SIZE * 3 / 4) ? 1 : 0;
        if (bp == 2) return (a >= SIZE / 2) ? 1 : 0;
        return 1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        int e_arr, e_sr, hw;
        chk(tag, "busy", int'(busy_o), m_rdy);
        chk(tag, "status.busy", int'(status_o[0]), m_rdy);
        chk(tag, "status.latch", int'(status_o[1]), m_wel);
        chk(tag, "reject", int'(reject_o), m_rej);
        chk(tag, "status[6:4]", int'(status_o[6:4]), 0);
        if (m_known != 0) begin
            hw    = (!wp_n_i && m_wpen != 0) ? 1 : 0;
            e_arr = (m_wel != 0 && is_prot(m_bp, int'(addr_i)) == 0 && m_rdy == 0) ? 1 : 0;
            e_sr  = (m_wel != 0 && hw == 0 && m_rdy == 0) ? 1 : 0;
            chk(tag, "status.en", int'(status_o[7]), m_wpen);
            chk(tag, "status.bp", int'(status_o[3:2]), m_bp);
            chk(tag, "arr_wr_ok", int'(arr_wr_ok_o), e_arr);
            chk(tag, "sr_wr_ok", int'(sr_wr_ok_o), e_sr);
        end else if (wp_n_i) begin
            e_sr = (m_wel != 0 && m_rdy == 0) ? 1 : 0;
            chk(tag, "sr_wr_ok", int'(sr_wr_ok_o), e_sr);
        end
    endtask

    task automatic model_edge();
        int hw;
        if (m_rdy != 0) begin
            m_rej = 0;
            m_cnt--;
            if (m_cnt == 0) begin
                m_rdy = 0;
                m_wel = 0;
            end
        end else begin
            m_rej = 0;
            hw = (!wp_n_i && m_wpen != 0) ? 1 : 0;
            if (wrsr_i) begin
                if (m_wel != 0 && hw == 0) begin
                    m_wpen  = int'(wrsr_data_i[7]);
                    m_bp    = int'(wrsr_data_i[3:2]);
                    m_known = 1;
                    m_rdy   = 1;
                    m_cnt   = NCYC;
                end else m_rej = 1;
            end else if (wrarr_i) begin
                if (m_wel != 0 && is_prot(m_bp, int'(addr_i)) == 0 && m_known != 0) begin
                    m_rdy = 1;
                    m_cnt = NCYC;
                end else m_rej = 1;
            end else if (wren_i) m_wel = 1;
            else if (wrdi_i) m_wel = 0;
        end
    endtask

    // one clock: inputs already on the pins, check mid-cycle, then advance
    task automatic cyc(string tag);
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wren_i = 0; wrdi_i = 0; wrsr_i = 0; wrarr_i = 0;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic do_wren(string tag);
        wren_i = 1; cyc(tag);
    endtask

    task automatic do_wrsr(string tag, logic [7:0] d);
        wrsr_i = 1; wrsr_data_i = d; cyc(tag);
    endtask

    task automatic do_arr(string tag, int a);
        wrarr_i = 1; addr_i = AW'(a); cyc(tag);
    endtask

    task automatic set_bp(string tag, logic [7:0] d);
        do_wren(tag);
        do_wrsr(tag, d);
        idle(tag, NCYC + 1);
    endtask

    task automatic do_reset(string tag);
        rst_n = 0;
        #1;
        m_wel = 0; m_rdy = 0; m_cnt = 0; m_rej = 0;
        compare(tag);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        idle("R1", 2);
        // R12 writes with latch clear
        do_arr("R12", 16'h0010);
        do_wrsr("R12", 8'h00);
        idle("R12", 1);
        // R2 set latch, then R7 initialise protection, R8 busy window
        do_wren("R2");
        do_wrsr("R7", 8'h00);
        idle("R8", NCYC);
        idle("R8", 1);
        // R2 set then clear
        do_wren("R2");
        wrdi_i = 1; cyc("R2");
        idle("R2", 1);
        // R3 quarter
        set_bp("R3", 8'h04);
        do_wren("R3");
        addr_i = 15'h6000; idle("R3", 1);
        addr_i = 15'h5FFF; idle("R3", 1);
        do_arr("R4", 16'h6000);
        idle("R4", 1);
        do_arr("R5", 16'h5FFF);
        // R9 strobes while busy
        wren_i = 1; wrsr_i = 1; wrsr_data_i = 8'h8C; cyc("R9");
        wrdi_i = 1; cyc("R9");
        do_arr("R9", 16'h0000);
        idle("R9", NCYC);
        // R3 half
        set_bp("R3", 8'h08);
        do_wren("R3");
        do_arr("R4", 16'h4000);
        do_arr("R5", 16'h3FFF);
        idle("R5", NCYC + 1);
        // R3 full
        set_bp("R3", 8'h0C);
        do_wren("R4");
        do_arr("R4", 16'h0000);
        do_arr("R4", 16'h7FFF);
        // R6 hardware lock with enable bit set, no protect range
        set_bp("R6", 8'h80);
        wp_n_i = 0;
        do_wren("R6");
        do_wrsr("R6", 8'h0C);
        idle("R6", 1);
        do_arr("R5", 16'h7FFF);
        idle("R5", NCYC + 1);
        // R7 pin high releases lock; data bit 0 ignored
        wp_n_i = 1;
        do_wren("R7");
        do_wrsr("R7", 8'h81);
        idle("R7", NCYC + 1);
        wp_n_i = 0;
        do_wren("R7");
        do_wrsr("R7", 8'h01);
        idle("R7", NCYC + 1);
        // R11 priority
        wren_i = 1; wrdi_i = 1; cyc("R11");
        wrarr_i = 1; addr_i = 15'h0001; wren_i = 1; wrdi_i = 1; cyc("R11");
        idle("R11", NCYC + 1);
        wp_n_i = 1;
        do_wren("R11");
        wrsr_i = 1; wrsr_data_i = 8'h88; wrarr_i = 1; addr_i = 15'h0002; cyc("R11");
        idle("R11", NCYC + 1);
        // R10 reset keeps protection bits
        do_wren("R10");
        do_reset("R10");
        idle("R10", 2);
        chk("R10", "status after reset", int'(status_o), 8'h88);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule